// File: doc/BRIEF.md
# Match-Triggered Watchdog Timer

This block is a memory-mapped watchdog. A 32-bit up-counter advances one step per clock while enabled. When the counter reaches a programmed match value, the block can take several actions, and each has its own enable: set an interrupt flag, wrap or halt the counter, drive an external match pin, and start a reset pulse. The reset pulse has a programmable length. It comes in two flavours, internal only or internal plus external. Software can also fire either flavour at once, without waiting for a match.

Software gives the timer a deadline by clearing the counter, loading the match register with the timeout multiplied by the counter clock rate, and enabling counting. It then keeps the system alive by repeating that sequence before the deadline. A sticky cause bit sits in a separate power-on domain. After the system comes back up, the bit tells software whether the last reset came from the watchdog. A debug-halt input can freeze the counter when the control register allows it.

Top module: `wdt_match_timer`

## Requirements
- R1: After power-on reset and system reset, every defined register reads 0 and the irq_o, rst_int_o, rst_ext_o and match_o outputs are low.
- R2: With bit 0 of the control register (word 1) set, the counter (word 2) increases by one per clock, starting on the edge after the write. Writing 0 to the control register freezes the counter and keeps its value.
- R3: Writing bit 1 of the control register clears the counter one edge after the write takes effect. A read right after that write still shows the old value. The counter then stays 0 for as long as bit 1 remains set.
- R4: When bit 2 of the control register is set and dbg_halt_i is high, the counter holds its value. When bit 2 is clear, dbg_halt_i has no effect.
- R5: A match event occurs on the edge where a running counter steps to the value of the match register (word 4). If match-control (word 3) bit 0 is set, the event sets the interrupt flag, which is word 0 bit 0 and drives irq_o. Writing 1 to that bit clears the flag. Writing 0 to it leaves the flag unchanged. With match-control bit 0 clear, the flag is not set.
- R6: On a match event, match-control bit 1 loads the counter with 0 instead of the match value. Match-control bit 2 clears control bit 0, so the counter stops at the match value.
- R7: On a match event, match-control bit 3 starts an internal reset pulse on rst_int_o. Bit 4 starts a pulse on both rst_int_o and rst_ext_o. The pulse starts on the match edge and lasts the value of the pulse register (word 6, 16 bits) plus 6 clocks.
- R8: A write to match control with bit 5 set starts an internal pulse at once. A write with bit 6 set starts an internal-plus-external pulse at once. Bits 5 and 6 always read back as 0.
- R9: Word 5 holds the match pin state in bit 0, which is writable and drives match_o, and an action code in bits [5:4]. On a match event, code 0 keeps the pin, 1 drives it low, 2 drives it high and 3 toggles it.
- R10: Bit 0 of word 7 is set when a reset pulse starts. It ignores writes and rst_ni, and only por_ni clears it.
- R11: Word addresses 8 to 15 are undefined. Writes to them change no register and no output, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter and bus clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| por_ni | input | 1 | Active-low asynchronous power-on reset for the pulse generator and cause bit |
| dbg_halt_i | input | 1 | Debug halt request |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | 4 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| irq_o | output | 1 | Match interrupt flag |
| rst_int_o | output | 1 | Internal reset pulse |
| rst_ext_o | output | 1 | External reset pulse |
| match_o | output | 1 | External match pin |

## Verification
The hardest case to reach from the ports is the cause bit surviving a system reset. To reach it, the bench first has to produce a complete reset pulse, then pull rst_ni while leaving por_ni alone, and only after that read the bit back. The bench gets there by firing forced pulses and match-triggered pulses across a sweep of pulse widths, counting each pulse cycle by cycle. It then pulses rst_ni, confirms that the other registers returned to their reset values while the cause bit stayed set, and finally drops por_ni.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned NREG = 8;

  localparam int unsigned W_INT   = 0;
  localparam int unsigned W_CTRL  = 1;
  localparam int unsigned W_CNT   = 2;
  localparam int unsigned W_MCTRL = 3;
  localparam int unsigned W_MATCH = 4;
  localparam int unsigned W_EMR   = 5;
  localparam int unsigned W_PULSE = 6;
  localparam int unsigned W_STAT  = 7;

  localparam int unsigned MC_IRQ  = 0;
  localparam int unsigned MC_WRAP = 1;
  localparam int unsigned MC_STOP = 2;
  localparam int unsigned MC_RES1 = 3;
  localparam int unsigned MC_RES2 = 4;
  localparam int unsigned MC_FRC1 = 5;
  localparam int unsigned MC_FRC2 = 6;

  typedef enum logic [1:0] {
    EM_KEEP   = 2'd0,
    EM_LOW    = 2'd1,
    EM_HIGH   = 2'd2,
    EM_TOGGLE = 2'd3
  } emr_act_e;
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic             freeze_i,
  input  logic [CNT_W-1:0] match_i,
  input  logic             wrap_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q, cnt_inc;
  logic             adv;

  assign adv     = run_i && !clr_i && !freeze_i;
  assign cnt_inc = cnt_q + CNT_W'(1);
  assign hit_o   = adv && (cnt_inc == match_i);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (hit_o && wrap_i)  cnt_q <= '0;
    else if (adv)              cnt_q <= cnt_inc;
  end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int unsigned PULSE_W     = 16,
  parameter int unsigned PULSE_EXTRA = 6
) (
  input  logic               clk_i,
  input  logic               por_ni,
  input  logic               trig_i,
  input  logic               ext_i,
  input  logic [PULSE_W-1:0] width_i,
  output logic               int_o,
  output logic               ext_o,
  output logic               cause_o
);
  localparam int unsigned LW = PULSE_W + 1;

  logic [LW-1:0] left_q;
  logic          ext_q, cause_q, active;

  assign active = (left_q != '0);

  // Lives in the power-on domain so the pulse and its cause outlast rst_ni.
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      left_q  <= '0;
      ext_q   <= 1'b0;
      cause_q <= 1'b0;
    end else if (trig_i && !active) begin
      left_q  <= LW'(width_i) + LW'(PULSE_EXTRA);
      ext_q   <= ext_i;
      cause_q <= 1'b1;
    end else if (active) begin
      left_q  <= left_q - LW'(1);
    end
  end

  assign int_o   = active;
  assign ext_o   = active && ext_q;
  assign cause_o = cause_q;
endmodule

// File: rtl/wdt_match_timer.sv
module wdt_match_timer
  import wdt_pkg::*;
#(
  parameter int unsigned DW          = 32,
  parameter int unsigned AW          = 4,
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned PULSE_W     = 16,
  parameter int unsigned PULSE_EXTRA = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          por_ni,
  input  logic          dbg_halt_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          rst_int_o,
  output logic          rst_ext_o,
  output logic          match_o
);
  localparam int unsigned MC_W = MC_RES2 + 1;

  logic [NREG-1:0]    wsel;
  logic               irq_q, en_q, clr_q, dbg_q, em_q;
  logic [MC_W-1:0]    mc_q;
  logic [CNT_W-1:0]   match_q, cnt;
  logic [PULSE_W-1:0] pw_q;
  emr_act_e           act_q;
  logic               hit, hit_rst, frc, trig, trig_ext, cause;

  always_comb begin
    for (int i = 0; i < NREG; i++)
      wsel[i] = req_i && we_i && (addr_i == AW'(i));
  end

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (en_q),
    .clr_i   (clr_q),
    .freeze_i(dbg_q && dbg_halt_i),
    .match_i (match_q),
    .wrap_i  (mc_q[MC_WRAP]),
    .cnt_o   (cnt),
    .hit_o   (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      clr_q <= 1'b0;
      dbg_q <= 1'b0;
    end else if (wsel[W_CTRL]) begin
      en_q  <= wdata_i[0];
      clr_q <= wdata_i[1];
      dbg_q <= wdata_i[2];
    end else if (hit && mc_q[MC_STOP]) begin
      en_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          irq_q <= 1'b0;
    else if (hit && mc_q[MC_IRQ])         irq_q <= 1'b1;
    else if (wsel[W_INT] && wdata_i[0])   irq_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mc_q    <= '0;
      match_q <= '0;
      pw_q    <= '0;
    end else begin
      if (wsel[W_MCTRL]) mc_q    <= wdata_i[MC_W-1:0];
      if (wsel[W_MATCH]) match_q <= wdata_i[CNT_W-1:0];
      if (wsel[W_PULSE]) pw_q    <= wdata_i[PULSE_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      em_q  <= 1'b0;
      act_q <= EM_KEEP;
    end else if (wsel[W_EMR]) begin
      em_q  <= wdata_i[0];
      act_q <= emr_act_e'(wdata_i[5:4]);
    end else if (hit) begin
      unique case (act_q)
        EM_KEEP:   em_q <= em_q;
        EM_LOW:    em_q <= 1'b0;
        EM_HIGH:   em_q <= 1'b1;
        EM_TOGGLE: em_q <= ~em_q;
      endcase
    end
  end

  assign hit_rst  = hit && (mc_q[MC_RES1] || mc_q[MC_RES2]);
  assign frc      = wsel[W_MCTRL] && (wdata_i[MC_FRC1] || wdata_i[MC_FRC2]);
  assign trig     = hit_rst || frc;
  assign trig_ext = (hit_rst && mc_q[MC_RES2]) || (frc && wdata_i[MC_FRC2]);

  wdt_pulse #(.PULSE_W(PULSE_W), .PULSE_EXTRA(PULSE_EXTRA)) u_pulse (
    .clk_i  (clk_i),
    .por_ni (por_ni),
    .trig_i (trig),
    .ext_i  (trig_ext),
    .width_i(pw_q),
    .int_o  (rst_int_o),
    .ext_o  (rst_ext_o),
    .cause_o(cause)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      AW'(W_INT):   rdata_o[0]   = irq_q;
      AW'(W_CTRL):  rdata_o[2:0] = {dbg_q, clr_q, en_q};
      AW'(W_CNT):   rdata_o      = DW'(cnt);
      AW'(W_MCTRL): rdata_o      = DW'(mc_q);
      AW'(W_MATCH): rdata_o      = DW'(match_q);
      AW'(W_EMR):   rdata_o[5:0] = {act_q, 3'b000, em_q};
      AW'(W_PULSE): rdata_o      = DW'(pw_q);
      AW'(W_STAT):  rdata_o[0]   = cause;
      default:      rdata_o      = '0;
    endcase
  end

  assign irq_o   = irq_q;
  assign match_o = em_q;
endmodule

// File: rtl/wdt_match_timer_chk.sv
module wdt_match_timer_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             por_ni,
  input logic             irq_o,
  input logic             rst_int_o,
  input logic             rst_ext_o,
  input logic             cause,
  input logic             hit,
  input logic             irq_en,
  input logic             stop_on,
  input logic             ctrl_wr,
  input logic             int_w1c,
  input logic             en_q,
  input logic             clr_q,
  input logic [CNT_W-1:0] cnt
);
  a_r7_ext_inside_int: assert property (@(posedge clk_i) disable iff (!por_ni)
    rst_ext_o |-> rst_int_o);

  a_r10_cause_with_pulse: assert property (@(posedge clk_i) disable iff (!por_ni)
    rst_int_o |-> cause);

  a_r10_cause_sticky: assert property (@(posedge clk_i) disable iff (!por_ni)
    cause |=> cause);

  a_r3_clear_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_q |=> (cnt == '0));

  a_r6_stop_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && stop_on && !ctrl_wr) |=> !en_q);

  a_r5_irq_on_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && irq_en) |=> irq_o);

  a_r5_irq_clear_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(int_w1c));
endmodule

bind wdt_match_timer wdt_match_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .por_ni   (por_ni),
  .irq_o    (irq_o),
  .rst_int_o(rst_int_o),
  .rst_ext_o(rst_ext_o),
  .cause    (cause),
  .hit      (hit),
  .irq_en   (mc_q[wdt_pkg::MC_IRQ]),
  .stop_on  (mc_q[wdt_pkg::MC_STOP]),
  .ctrl_wr  (wsel[wdt_pkg::W_CTRL]),
  .int_w1c  (wsel[wdt_pkg::W_INT] && wdata_i[0]),
  .en_q     (en_q),
  .clr_q    (clr_q),
  .cnt      (cnt)
);

// File: tb/wdt_match_timer_tb.sv
module wdt_match_timer_tb;
  import wdt_pkg::*;
  localparam int CLK_P = 10;
  localparam int EXTRA = 6;

  logic        clk = 1'b0, rst_n = 1'b0, por_n = 1'b0, halt = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq, rst_int, rst_ext, mpin;
  int          checks = 0, fails = 0;

  wdt_match_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .dbg_halt_i(halt),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_o(irq), .rst_int_o(rst_int), .rst_ext_o(rst_ext), .match_o(mpin)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a[3:0]; wdata = d;
    @(posedge clk); @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    addr = a[3:0]; #1; d = rdata;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_cnt();
    wr(W_CTRL, 32'h2); wr(W_CTRL, 32'h0);
  endtask

  task automatic pulse_len(output int n);
    n = 0;
    while (rst_int && n < 100000) begin n++; @(negedge clk); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    step(3); rst_n = 1'b1; por_n = 1'b1; step(1);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin rd(a, v); chk("R1 reg", v, 0); end
    chk("R1 outs", {irq, rst_int, rst_ext, mpin}, 0);

    // R2 counting, R3 delayed clear
    clr_cnt(); wr(W_CTRL, 1); step(5);
    rd(W_CNT, v); chk("R2 count", v, 5);
    wr(W_CTRL, 3); rd(W_CNT, v); chk("R3 not instant", v, 6);
    step(1); rd(W_CNT, v); chk("R3 cleared", v, 0);
    step(2); rd(W_CNT, v); chk("R3 held zero", v, 0);
    wr(W_CTRL, 1); step(4); rd(W_CNT, v); chk("R2 recount", v, 4);
    wr(W_CTRL, 0); rd(W_CNT, v); chk("R2 stop edge", v, 5);
    step(3); rd(W_CNT, v); chk("R2 hold", v, 5);

    // R4 debug freeze
    clr_cnt(); halt = 1'b1; wr(W_CTRL, 5); step(4);
    rd(W_CNT, v); chk("R4 frozen", v, 0);
    halt = 1'b0; step(3); rd(W_CNT, v); chk("R4 released", v, 3);
    halt = 1'b1; wr(W_CTRL, 1); rd(W_CNT, v); chk("R4 last frozen edge", v, 3);
    step(2); rd(W_CNT, v); chk("R4 halt ignored", v, 5);
    wr(W_CTRL, 0); halt = 1'b0;

    // R5/R6 match sweep with irq and stop
    for (int m = 1; m <= 6; m++) begin
      clr_cnt(); wr(W_MATCH, m); wr(W_MCTRL, 32'h5); wr(W_INT, 1); wr(W_CTRL, 1);
      step(m - 1);
      rd(W_CNT, v); chk("R5 before match cnt", v, m - 1);
      chk("R5 before match irq", irq, 0);
      step(1);
      rd(W_CNT, v); chk("R5 at match cnt", v, m);
      chk("R5 irq set", irq, 1);
      step(3);
      rd(W_CNT, v); chk("R6 stopped", v, m);
      rd(W_CTRL, v); chk("R6 enable cleared", v, 0);
      rd(W_INT, v); chk("R5 flag reg", v, 1);
      wr(W_INT, 0); chk("R5 write0 keeps", irq, 1);
      wr(W_INT, 1); chk("R5 w1c", irq, 0);
    end

    // R6 wrap on match, R5 irq disabled
    clr_cnt(); wr(W_MATCH, 4); wr(W_MCTRL, 32'h2); wr(W_CTRL, 1);
    step(3); rd(W_CNT, v); chk("R6 pre wrap", v, 3);
    step(1); rd(W_CNT, v); chk("R6 wrapped", v, 0);
    chk("R5 irq disabled", irq, 0);
    step(1); rd(W_CNT, v); chk("R6 after wrap", v, 1);
    wr(W_CTRL, 0);

    // R9 external match actions, exhaustive over code and state
    for (int act = 0; act < 4; act++)
      for (int s = 0; s < 2; s++) begin
        logic e;
        e = (act == 0) ? s[0] : (act == 1) ? 1'b0 : (act == 2) ? 1'b1 : ~s[0];
        clr_cnt(); wr(W_MATCH, 3); wr(W_MCTRL, 32'h4);
        wr(W_EMR, (act << 4) | s); wr(W_CTRL, 1);
        step(2); chk("R9 before match", mpin, s);
        step(1); chk("R9 after match", mpin, e);
        rd(W_EMR, v); chk("R9 readback", v, (act << 4) | e);
      end

    // R8/R7 forced pulses, width sweep
    for (int mode = 1; mode <= 2; mode++)
      for (int pw = 0; pw < 6; pw++) begin
        wr(W_PULSE, pw); wr(W_MCTRL, (mode == 1) ? 32'h20 : 32'h40);
        chk("R8 forced int", rst_int, 1);
        chk("R8 forced ext", rst_ext, (mode == 2));
        rd(W_MCTRL, v); chk("R8 force bits read 0", v, 0);
        rd(W_STAT, v); chk("R10 cause set", v, 1);
        pulse_len(n); chk("R7 forced length", n, pw + EXTRA);
      end

    // R7 match-triggered pulses
    for (int b = 3; b <= 4; b++) begin
      wr(W_PULSE, 2); clr_cnt(); wr(W_MATCH, 5);
      wr(W_MCTRL, (1 << b) | 4); wr(W_CTRL, 1);
      step(4); chk("R7 no early pulse", rst_int, 0);
      step(1); chk("R7 pulse at match", rst_int, 1);
      chk("R7 ext select", rst_ext, (b == 4));
      pulse_len(n); chk("R7 match length", n, 2 + EXTRA);
    end

    // R10 sticky cause across system reset
    rst_n = 1'b0; step(2); rst_n = 1'b1; step(1);
    rd(W_STAT, v); chk("R10 survives rst", v, 1);
    rd(W_MATCH, v); chk("R1 match after rst", v, 0);
    wr(W_STAT, 0); rd(W_STAT, v); chk("R10 write ignored", v, 1);
    por_n = 1'b0; rst_n = 1'b0; step(1); por_n = 1'b1; rst_n = 1'b1; step(1);
    rd(W_STAT, v); chk("R10 por clears", v, 0);

    // R11 undefined offsets
    wr(W_MATCH, 32'h1234); wr(W_PULSE, 7);
    for (int a = 8; a < 16; a++) begin
      wr(a, 32'hFFFF_FFFF); rd(a, v); chk("R11 read zero", v, 0);
    end
    rd(W_MATCH, v); chk("R11 match intact", v, 32'h1234);
    rd(W_PULSE, v); chk("R11 pulse intact", v, 7);
    rd(W_CTRL, v);  chk("R11 ctrl intact", v, 0);
    chk("R11 outputs quiet", {irq, rst_int, rst_ext, mpin}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule